// File: doc/BRIEF.md
# Completion Timeout Tracker

This block watches non-posted requests that are waiting for their completions. Each request carries a small tag. When a request is issued, the block starts an age counter for that tag. When the matching completion returns, the block stops watching the tag. If no completion arrives before the programmed limit, the block raises a one-cycle timeout event that carries the expired tag. A `busy` output stays high while any tag is outstanding.

Time comes in as a prescaled tick of 1 µs. A 4-bit select chooses the limit from eight values, which form four coarse bins of two sub-ranges each. Each range has its own divider and terminal count, so the per-tag counters stay narrow. A disable input turns detection off completely. A constant capability output reports which bins the instance supports.

Top module: `cto_timer`

## Requirements
- R1: After reset, `to_evt` is low and `busy` is low.
- R2: After an issue is sampled, `busy` is high on the next cycle. `busy` is high exactly while at least one tag is outstanding.
- R3: Range select 0 gives a limit of 50 ticks. With `tick_us` held high, `to_evt` rises 51 clock edges after the edge that sampled the issue. While `tick_us` is low, the age does not advance.
- R4: The select is decoded as bin = `range_sel[2:1]` and sub-range = `range_sel[0]`. The eight limits, as divider × count in ticks, are: 0 = 1×50 (50 µs), 1 = 100×100 (10 ms), 2 = 1000×55 (55 ms), 3 = 1000×210 (210 ms), 4 = 10000×90 (900 ms), 5 = 100000×35 (3.5 s), 6 = 100000×130 (13 s), 7 = 1000000×64 (64 s). The shared divider is free-running, so the event comes between (count−1)×div+2 and count×div+1 edges after the issue.
- R5: A completion for an outstanding tag, sampled before its age reaches the limit, cancels the timeout. No event follows, and `busy` drops once no other tag is outstanding.
- R6: A completion for a tag that is not outstanding has no effect on any other tag's timing.
- R7: An issue for a tag that is already outstanding restarts that tag's age from zero. An issue wins over a completion for the same tag in the same cycle.
- R8: While `to_disable` is high, no timeout event is raised. Ages saturate at the limit. Once `to_disable` falls, expired tags are reported starting on the next edge.
- R9: If several tags are expired at once, one event is raised per cycle, with the lowest-numbered tag first.
- R10: A select with `range_sel[3]` set, or one that names a bin not flagged in `cap_bins`, behaves as select 0.
- R11: `cap_bins` bit i is 1 when bin i is supported. It equals the `SUPPORTED_BINS` parameter (default 4'b0111) and never changes.
- R12: Each expiry produces a single one-cycle event, and the reported tag is no longer outstanding afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A non-posted request is issued this cycle |
| req_tag | input | TAG_W | Tag of the issued request |
| cpl_vld | input | 1 | A completion is received this cycle |
| cpl_tag | input | TAG_W | Tag of the received completion |
| range_sel | input | 4 | Timeout range select |
| to_disable | input | 1 | Turns off timeout detection |
| tick_us | input | 1 | Prescaled 1 µs time tick |
| to_evt | output | 1 | One-cycle timeout event |
| to_evt_tag | output | TAG_W | Tag that timed out |
| busy | output | 1 | At least one tag is outstanding |
| cap_bins | output | 4 | Supported bins, one bit per bin |

## Verification
The assertions assume that at most one issue and one completion arrive per cycle. They also assume that `cap_bins` is tied off and never driven from outside. Under those assumptions the arbiter grant must always be one-hot or zero, and it must name an expired tag. The stimulus presents at most one request and one completion per cycle through single-cycle tasks. It changes the range select and the disable bit only on falling edges. The random phase holds the select at 0 and `tick_us` high, so the bench model can predict the exact deadline of each tag.

// File: rtl/cto_pkg.sv
package cto_pkg;
  localparam int DIV_W = 20;
  localparam int CNT_W = 8;

  // ticks per age step for each of the eight ranges
  function automatic logic [DIV_W-1:0] range_div(input logic [2:0] r);
    case (r)
      3'd0:    return DIV_W'(1);
      3'd1:    return DIV_W'(100);
      3'd2:    return DIV_W'(1000);
      3'd3:    return DIV_W'(1000);
      3'd4:    return DIV_W'(10000);
      3'd5:    return DIV_W'(100000);
      3'd6:    return DIV_W'(100000);
      default: return DIV_W'(1000000);
    endcase
  endfunction

  // age steps until expiry for each range
  function automatic logic [CNT_W-1:0] range_cnt(input logic [2:0] r);
    case (r)
      3'd0:    return CNT_W'(50);
      3'd1:    return CNT_W'(100);
      3'd2:    return CNT_W'(55);
      3'd3:    return CNT_W'(210);
      3'd4:    return CNT_W'(90);
      3'd5:    return CNT_W'(35);
      3'd6:    return CNT_W'(130);
      default: return CNT_W'(64);
    endcase
  endfunction

  // reserved or unsupported selects fall back to range 0
  function automatic logic [2:0] effective_range(input logic [3:0] sel, input logic [3:0] caps);
    if (sel[3] || !caps[sel[2:1]]) return 3'd0;
    return sel[2:0];
  endfunction
endpackage

// File: rtl/cto_range_decode.sv
module cto_range_decode
  import cto_pkg::*;
#(
  parameter logic [3:0] SUPPORTED_BINS = 4'b0111
) (
  input  logic [3:0]       range_sel,
  output logic [DIV_W-1:0] step_div,
  output logic [CNT_W-1:0] limit_cnt
);
  logic [2:0] eff;
  always_comb begin
    eff       = effective_range(range_sel, SUPPORTED_BINS);
    step_div  = range_div(eff);
    limit_cnt = range_cnt(eff);
  end
endmodule

// File: rtl/cto_prescaler.sv
module cto_prescaler
  import cto_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic [DIV_W-1:0] step_div,
  output logic             step
);
  logic [DIV_W-1:0] pre_cnt;

  // >= keeps the counter bounded when the divider shrinks
  assign step = tick_us && (pre_cnt >= step_div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (step)    pre_cnt <= '0;
    else if (tick_us) pre_cnt <= pre_cnt + DIV_W'(1);
  end
endmodule

// File: rtl/cto_tag_slot.sv
module cto_tag_slot
  import cto_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  input  logic             grant,
  input  logic             step,
  input  logic             detect_en,
  input  logic [CNT_W-1:0] limit_cnt,
  output logic             valid,
  output logic             expired
);
  logic [CNT_W-1:0] age;
  logic             at_limit;

  assign at_limit = age >= limit_cnt;
  assign expired  = valid && at_limit && detect_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      age   <= '0;
    end else if (issue) begin
      valid <= 1'b1;
      age   <= '0;
    end else if (retire || grant) begin
      valid <= 1'b0;
    end else if (valid && step && !at_limit) begin
      age <= age + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cto_pick_lowest.sv
module cto_pick_lowest #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // isolate lowest set bit
  assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/cto_timer.sv
module cto_timer
  import cto_pkg::*;
#(
  parameter int         NUM_TAGS       = 8,
  parameter logic [3:0] SUPPORTED_BINS = 4'b0111,
  localparam int        TAG_W          = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cpl_vld,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [3:0]       range_sel,
  input  logic             to_disable,
  input  logic             tick_us,
  output logic             to_evt,
  output logic [TAG_W-1:0] to_evt_tag,
  output logic             busy,
  output logic [3:0]       cap_bins
);
  logic [DIV_W-1:0]    step_div;
  logic [CNT_W-1:0]    limit_cnt;
  logic                step;
  logic [NUM_TAGS-1:0] valid_vec;
  logic [NUM_TAGS-1:0] expired_vec;
  logic [NUM_TAGS-1:0] grant_vec;
  logic [TAG_W-1:0]    grant_tag;

  cto_range_decode #(.SUPPORTED_BINS(SUPPORTED_BINS)) u_dec (
    .range_sel (range_sel),
    .step_div  (step_div),
    .limit_cnt (limit_cnt)
  );

  cto_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .step_div (step_div),
    .step     (step)
  );

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    cto_tag_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (req_vld && (req_tag == TAG_W'(g))),
      .retire    (cpl_vld && (cpl_tag == TAG_W'(g))),
      .grant     (grant_vec[g]),
      .step      (step),
      .detect_en (!to_disable),
      .limit_cnt (limit_cnt),
      .valid     (valid_vec[g]),
      .expired   (expired_vec[g])
    );
  end

  cto_pick_lowest #(.N(NUM_TAGS)) u_pick (
    .req (expired_vec),
    .gnt (grant_vec)
  );

  always_comb begin
    grant_tag = '0;
    for (int i = 0; i < NUM_TAGS; i++)
      if (grant_vec[i]) grant_tag = grant_tag | TAG_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_evt     <= 1'b0;
      to_evt_tag <= '0;
    end else begin
      to_evt     <= |grant_vec;
      to_evt_tag <= grant_tag;
    end
  end

  assign busy     = |valid_vec;
  assign cap_bins = SUPPORTED_BINS;
endmodule

// File: rtl/cto_timer_chk.sv
module cto_timer_chk #(
  parameter int NUM_TAGS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic                to_disable,
  input logic                to_evt,
  input logic                busy,
  input logic [3:0]          cap_bins,
  input logic [NUM_TAGS-1:0] expired_vec,
  input logic [NUM_TAGS-1:0] grant_vec
);
  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> !$past(to_disable));

  a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> busy);

  a_r12_event_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> $past(busy));

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r9_grant_is_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~expired_vec) == '0);

  a_r9_pending_is_served: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_vec != '0) |-> (grant_vec != '0));

  a_r11_caps_constant: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cap_bins));
endmodule

bind cto_timer cto_timer_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .to_disable  (to_disable),
  .to_evt      (to_evt),
  .busy        (busy),
  .cap_bins    (cap_bins),
  .expired_vec (expired_vec),
  .grant_vec   (grant_vec)
);

// File: tb/cto_timer_tb.sv
module cto_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld, cpl_vld, to_disable, tick_us;
  logic [TW-1:0] req_tag, cpl_tag;
  logic [3:0]    range_sel;
  logic          to_evt, busy;
  logic [TW-1:0] to_evt_tag;
  logic [3:0]    cap_bins;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cto_timer u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tag(req_tag),
    .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .range_sel(range_sel),
    .to_disable(to_disable), .tick_us(tick_us), .to_evt(to_evt),
    .to_evt_tag(to_evt_tag), .busy(busy), .cap_bins(cap_bins)
  );

  // bench view of the range table: limit = div * cnt ticks
  function automatic int tb_div(input int s);
    int d[8] = '{1, 100, 1000, 1000, 10000, 100000, 100000, 1000000};
    return d[s];
  endfunction
  function automatic int tb_cnt(input int s);
    int c[8] = '{50, 100, 55, 210, 90, 35, 130, 64};
    return c[s];
  endfunction
  function automatic int tb_sel(input int s, input int caps);
    int bin = (s >> 1) & 3;
    if (s >= 8 || ((caps >> bin) & 1) == 0) return 0;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_issue(input int t);
    req_vld = 1'b1; req_tag = TW'(t);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic do_cpl(input int t);
    cpl_vld = 1'b1; cpl_tag = TW'(t);
    @(negedge clk);
    cpl_vld = 1'b0;
  endtask

  task automatic idle(input int n, output int evts);
    evts = 0;
    repeat (n) begin
      @(negedge clk);
      if (to_evt) evts++;
    end
  endtask

  task automatic wait_evt(input int max, output int n, output int tg);
    n = 0; tg = -1;
    while (n < max) begin
      @(negedge clk);
      n++;
      if (to_evt) begin tg = int'(to_evt_tag); break; end
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, tg, ev, lo, hi, s;
    bit mv[NT];
    int dl[NT];
    int e;
    bit rv, cv, xe;
    int rt, ct, xt, anyv;

    rst_n = 0; req_vld = 0; cpl_vld = 0; req_tag = '0; cpl_tag = '0;
    range_sel = 4'd0; to_disable = 0; tick_us = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R11 reset state and capability
    check(!to_evt, "R1 evt", int'(to_evt), 0);
    check(!busy, "R1 busy", int'(busy), 0);
    check(cap_bins == 4'b0111, "R11 caps", int'(cap_bins), 7);

    // R3 exact limit, R2 busy, R12 single pulse
    do_issue(3);
    check(busy, "R2 busy after issue", int'(busy), 1);
    wait_evt(200, n, tg);
    check(n == 51, "R3 cycles", n, 51);
    check(tg == 3, "R3 tag", tg, 3);
    @(negedge clk);
    check(!to_evt, "R12 single pulse", int'(to_evt), 0);
    check(!busy, "R12 tag retired", int'(busy), 0);

    // R3 age frozen without ticks
    tick_us = 0;
    do_issue(3);
    idle(200, ev);
    check(ev == 0, "R3 no tick no event", ev, 0);
    tick_us = 1;
    wait_evt(200, n, tg);
    check(n == 51, "R3 cycles after ticks resume", n, 51);

    // R5 completion cancels
    do_issue(2);
    idle(20, ev);
    do_cpl(2);
    idle(60, ev);
    check(ev == 0, "R5 no event after completion", ev, 0);
    check(!busy, "R5 busy dropped", int'(busy), 0);

    // R6 stray completion ignored
    do_issue(1);
    idle(10, ev);
    do_cpl(5);
    wait_evt(200, n, tg);
    check(n == 51 - 11, "R6 timing unaffected", n, 40);
    check(tg == 1, "R6 tag", tg, 1);

    // R7 reissue restarts
    do_issue(4);
    idle(30, ev);
    do_issue(4);
    wait_evt(200, n, tg);
    check(n == 51 && tg == 4, "R7 restart", n, 51);

    // R8 disable, then R9 ordering
    to_disable = 1;
    do_issue(0);
    idle(100, ev);
    check(ev == 0, "R8 no event while disabled", ev, 0);
    check(busy, "R8 still outstanding", int'(busy), 1);
    do_issue(6);
    do_issue(2);
    idle(60, ev);
    check(ev == 0, "R8 still quiet", ev, 0);
    to_disable = 0;
    @(negedge clk);
    check(to_evt && to_evt_tag == 3'd0, "R9 first lowest", int'(to_evt_tag), 0);
    @(negedge clk);
    check(to_evt && to_evt_tag == 3'd2, "R9 second", int'(to_evt_tag), 2);
    @(negedge clk);
    check(to_evt && to_evt_tag == 3'd6, "R9 third", int'(to_evt_tag), 6);
    @(negedge clk);
    check(!to_evt && !busy, "R12 all retired", int'(busy), 0);

    // R10 fallback selects
    foreach (s_list[k]) begin end
    for (int k = 0; k < 2; k++) begin
      s = (k == 0) ? 6 : 9;
      check(tb_sel(s, 7) == 0, "R10 bench decode", tb_sel(s, 7), 0);
      range_sel = 4'(s);
      do_issue(5);
      wait_evt(200, n, tg);
      check(n == 51, "R10 fallback cycles", n, 51);
    end

    // R4 longer ranges with free-running divider
    for (int k = 1; k <= 2; k++) begin
      range_sel = 4'(k);
      lo = (tb_cnt(k) - 1) * tb_div(k) + 2;
      hi = tb_cnt(k) * tb_div(k) + 1;
      do_issue(7);
      wait_evt(hi + 5, n, tg);
      check(n >= lo && n <= hi && tg == 7, "R4 window", n, hi);
    end
    range_sel = 4'd0;
    idle(5, ev);

    // random phase, range 0, bench model of deadlines (R2, R3, R5, R6, R7, R12)
    for (int t = 0; t < NT; t++) begin mv[t] = 0; dl[t] = 0; end
    e = 0;
    for (int it = 0; it < 3000; it++) begin
      rv = ($urandom % 4) == 0; rt = $urandom % NT;
      cv = ($urandom % 5) == 0; ct = $urandom % NT;
      req_vld = rv; req_tag = TW'(rt);
      cpl_vld = cv; cpl_tag = TW'(ct);
      @(negedge clk);
      e++;
      xe = 0; xt = 0;
      for (int t = 0; t < NT; t++)
        if (mv[t] && dl[t] == e) begin xe = 1; xt = t; mv[t] = 0; end
      if (cv) mv[ct] = 0;
      if (rv) begin mv[rt] = 1; dl[rt] = e + 51; end
      anyv = 0;
      for (int t = 0; t < NT; t++) anyv |= int'(mv[t]);
      check(to_evt == xe, "R3 random event", int'(to_evt), int'(xe));
      if (xe) check(int'(to_evt_tag) == xt, "R12 random tag", int'(to_evt_tag), xt);
      check(int'(busy) == anyv, "R2 random busy", int'(busy), anyv);
    end
    req_vld = 0; cpl_vld = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int s_list[1];
  initial $urandom(32'd1234);
endmodule